// File: doc/BRIEF.md
# Up-down PWM generator

The block generates center-aligned pulse-width modulation from a triangle counter. The counter climbs from zero to a programmable period and falls back to zero, so one full cycle lasts twice the period in clocks. Two compare channels, A and B, each take a compare value from a shadow input. The value is copied into the working register at the bottom and at the top of the triangle. A per-channel action table turns counter events into set, clear or toggle operations on a registered raw output. The table has one entry for the zero event, one for the period event, one for an up-counting match and one for a down-counting match.

The host picks the period and the compare values, and may pull the counter to a phase value through a sync input. A two-bit force setting per output pins that output low or high at once, without waiting for any load point. Zero, period and sync-out strobes report where the counter is, so other timers can be aligned to this one.

Top module: `updown_pwm`

## Requirements
- R1: While reset is held and enable is low, both outputs and all three strobes are 0. The counter starts at zero, so the first enabled clock shows a zero strobe.
- R2: With period P > 0 and no sync, zero strobes are 2P clocks apart. Each period strobe comes P clocks after a zero strobe. P = 750 gives 1500 clocks.
- R3: The zero and period strobes each last one clock per cycle. sync_o pulses in exactly the clocks where zero_o pulses.
- R4: A compare shadow value is copied to the working register only at a zero or period strobe. A shadow change made between those points has no effect until the next one.
- R5: With the default actions and 0 < C < P, an up-counting match at C clears the output and a down-counting match at C sets it. The output is therefore high for 2C clocks out of every 2P.
- R6: A compare value of 0 matches only at the bottom turnaround, as a down match, so the default output stays high. A compare value at or above P never matches, so the output keeps its level.
- R7: Action codes are 00 none, 01 clear, 10 set, 11 toggle, applied in the order zero, period, compare. When events coincide, the later one wins.
- R8: When phase_en_i is 1, a sync_i pulse loads phase_i into the counter on that clock and the counter then counts up. When phase_en_i is 0, sync_i has no effect.
- R9: The force code takes effect in the same clock: 01 drives the output low, 10 drives it high, and 00 or 11 passes the action-qualified level. The level underneath keeps updating while forced.
- R10: While en_i is 0, the counter and the raw outputs hold and no strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Count enable |
| period_i | input | CNT_W | Triangle peak value P |
| cmp_a_i | input | CNT_W | Shadow compare value, channel A |
| cmp_b_i | input | CNT_W | Shadow compare value, channel B |
| sync_i | input | 1 | Sync pulse for phase load |
| phase_en_i | input | 1 | Allows sync_i to load the phase |
| phase_i | input | CNT_W | Value loaded into the counter on sync |
| force_a_i | input | 2 | Force code, output A |
| force_b_i | input | 2 | Force code, output B |
| pwm_a_o | output | 1 | PWM output A |
| pwm_b_o | output | 1 | PWM output B |
| zero_o | output | 1 | Counter-at-zero strobe |
| period_o | output | 1 | Counter-at-period strobe |
| sync_o | output | 1 | Sync-out strobe |

## Verification
The strobes are decoded from the counter register, so they appear in the clock after the edge that moves the counter. A sync load is therefore seen P-phase+1 edges after the zero strobe it coincides with. A compare action lands on the raw output one edge after the match count, which makes the high time exactly 2C clocks. A force code changes the output in the same clock, with no edge in between. The bench drives inputs on falling edges and samples on falling edges. Force checks are taken a delta later, in the same clock. Duty measurements count high clocks over a 2P window only after a settling interval longer than two cycles, so every shadow load has already happened.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_CLR  = 2'b01,
    ACT_SET  = 2'b10,
    ACT_TGL  = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    FRC_OFF  = 2'b00,
    FRC_LOW  = 2'b01,
    FRC_HIGH = 2'b10,
    FRC_PASS = 2'b11
  } frc_e;

  typedef struct packed {
    act_e zro;
    act_e prd;
    act_e cmp_up;
    act_e cmp_dn;
  } act_cfg_t;

  localparam act_cfg_t ACT_DEFAULT = '{zro: ACT_NONE, prd: ACT_NONE,
                                       cmp_up: ACT_CLR, cmp_dn: ACT_SET};

  function automatic logic apply_act(input logic cur, input act_e a);
    case (a)
      ACT_CLR: apply_act = 1'b0;
      ACT_SET: apply_act = 1'b1;
      ACT_TGL: apply_act = ~cur;
      default: apply_act = cur;
    endcase
  endfunction
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             sync_i,
  input  logic             phase_en_i,
  input  logic [CNT_W-1:0] phase_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_up_o,
  output logic             zero_o,
  output logic             prd_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             up_q, up_d;

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (en_i) begin
      if (sync_i && phase_en_i) begin
        cnt_d = phase_i;
        up_d  = 1'b1;
      end else if (period_i == '0) begin
        cnt_d = '0;
        up_d  = 1'b0;
      end else if (up_q) begin
        if (cnt_q >= period_i) begin
          cnt_d = cnt_q - ONE;
          up_d  = 1'b0;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else if (cnt_q == '0) begin
        cnt_d = ONE;
        up_d  = 1'b1;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  // reset with direction down so the first zero is a turnaround
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign dir_up_o = up_q;
  assign zero_o   = en_i && (cnt_q == '0);
  assign prd_o    = en_i && (cnt_q == period_i);
endmodule

// File: rtl/pwm_cmp_shadow.sv
module pwm_cmp_shadow #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] shadow_i,
  output logic [CNT_W-1:0] active_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     active_o <= '0;
    else if (load_i) active_o <= shadow_i;
  end
endmodule

// File: rtl/pwm_aq.sv
module pwm_aq
  import pwm_pkg::*;
#(
  parameter int       CNT_W = 16,
  parameter act_cfg_t CFG   = ACT_DEFAULT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             dir_up_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             zero_i,
  input  logic             prd_i,
  input  logic [1:0]       force_i,
  output logic             pwm_o,
  output logic             raw_o
);
  logic raw_q, raw_d;
  logic hit_up, hit_dn;

  // zero compare fires only as a down match; cmp >= period never matches going up
  assign hit_up = en_i && dir_up_i && (cmp_i != '0) && (cmp_i < period_i) && (cnt_i == cmp_i);
  assign hit_dn = en_i && !dir_up_i && (cnt_i == cmp_i);

  always_comb begin
    raw_d = raw_q;
    if (zero_i) raw_d = apply_act(raw_d, CFG.zro);
    if (prd_i)  raw_d = apply_act(raw_d, CFG.prd);
    if (hit_up) raw_d = apply_act(raw_d, CFG.cmp_up);
    if (hit_dn) raw_d = apply_act(raw_d, CFG.cmp_dn);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   raw_q <= 1'b0;
    else if (en_i) raw_q <= raw_d;
  end

  always_comb begin
    case (frc_e'(force_i))
      FRC_LOW:  pwm_o = 1'b0;
      FRC_HIGH: pwm_o = 1'b1;
      default:  pwm_o = raw_q;
    endcase
  end

  assign raw_o = raw_q;
endmodule

// File: rtl/updown_pwm.sv
module updown_pwm
  import pwm_pkg::*;
#(
  parameter int       CNT_W = 16,
  parameter act_cfg_t ACT_A = ACT_DEFAULT,
  parameter act_cfg_t ACT_B = ACT_DEFAULT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] cmp_a_i,
  input  logic [CNT_W-1:0] cmp_b_i,
  input  logic             sync_i,
  input  logic             phase_en_i,
  input  logic [CNT_W-1:0] phase_i,
  input  logic [1:0]       force_a_i,
  input  logic [1:0]       force_b_i,
  output logic             pwm_a_o,
  output logic             pwm_b_o,
  output logic             zero_o,
  output logic             period_o,
  output logic             sync_o
);
  localparam int NUM_CH = 2;

  logic [CNT_W-1:0]              cnt;
  logic                          dir_up;
  logic                          zero_ev, prd_ev;
  logic [NUM_CH-1:0][CNT_W-1:0]  cmp_sh, cmp_act;
  logic [NUM_CH-1:0][1:0]        frc;
  logic [NUM_CH-1:0]             pwm, raw;

  assign cmp_sh[0] = cmp_a_i;
  assign cmp_sh[1] = cmp_b_i;
  assign frc[0]    = force_a_i;
  assign frc[1]    = force_b_i;

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .period_i   (period_i),
    .sync_i     (sync_i),
    .phase_en_i (phase_en_i),
    .phase_i    (phase_i),
    .cnt_o      (cnt),
    .dir_up_o   (dir_up),
    .zero_o     (zero_ev),
    .prd_o      (prd_ev)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_cmp_shadow #(.CNT_W(CNT_W)) u_sh (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (zero_ev || prd_ev),
      .shadow_i (cmp_sh[g]),
      .active_o (cmp_act[g])
    );

    pwm_aq #(.CNT_W(CNT_W), .CFG((g == 0) ? ACT_A : ACT_B)) u_aq (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (en_i),
      .cnt_i    (cnt),
      .dir_up_i (dir_up),
      .period_i (period_i),
      .cmp_i    (cmp_act[g]),
      .zero_i   (zero_ev),
      .prd_i    (prd_ev),
      .force_i  (frc[g]),
      .pwm_o    (pwm[g]),
      .raw_o    (raw[g])
    );
  end

  assign pwm_a_o  = pwm[0];
  assign pwm_b_o  = pwm[1];
  assign zero_o   = zero_ev;
  assign period_o = prd_ev;
  assign sync_o   = zero_ev;
endmodule

// File: rtl/updown_pwm_chk.sv
module updown_pwm_chk #(
  parameter int CNT_W = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  en_i,
  input logic                  sync_i,
  input logic                  phase_en_i,
  input logic [CNT_W-1:0]      period_i,
  input logic [1:0]            force_a_i,
  input logic [1:0]            force_b_i,
  input logic                  pwm_a_o,
  input logic                  pwm_b_o,
  input logic                  zero_o,
  input logic                  period_o,
  input logic [1:0]            raw_i,
  input logic [1:0][CNT_W-1:0] cmp_act_i
);
  p_zero_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o && (period_i != '0) && !(sync_i && phase_en_i) |=> !zero_o);

  p_prd_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_o && (period_i != '0) && !(sync_i && phase_en_i)
    |=> !period_o || (period_i != $past(period_i)));

  p_load_point_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cmp_act_i) |-> $past(zero_o || period_o));

  p_force_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_a_i == 2'b01) |-> !pwm_a_o);

  p_force_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_b_i == 2'b10) |-> pwm_b_o);

  p_no_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !zero_o && !period_o);

  p_raw_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(raw_i));
endmodule

bind updown_pwm updown_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .sync_i     (sync_i),
  .phase_en_i (phase_en_i),
  .period_i   (period_i),
  .force_a_i  (force_a_i),
  .force_b_i  (force_b_i),
  .pwm_a_o    (pwm_a_o),
  .pwm_b_o    (pwm_b_o),
  .zero_o     (zero_o),
  .period_o   (period_o),
  .raw_i      (raw),
  .cmp_act_i  (cmp_act)
);

// File: tb/updown_pwm_bench.sv
`timescale 1ns/1ps
module updown_pwm_bench;
  localparam int CNT_W = 16;
  localparam pwm_pkg::act_cfg_t ALT_B = '{zro: pwm_pkg::ACT_CLR, prd: pwm_pkg::ACT_NONE,
                                          cmp_up: pwm_pkg::ACT_NONE, cmp_dn: pwm_pkg::ACT_SET};
  // period, cmp_a, cmp_b, high clocks of A, high clocks of B per 2P window
  localparam int NVEC = 7;
  localparam int VEC [NVEC][5] = '{
    '{10,  3,  5,  6, 10},
    '{10,  9,  1, 18,  2},
    '{20,  7, 12, 14, 24},
    '{ 8,  0,  4, 16,  8},
    '{ 8,  8,  2, 16,  4},
    '{ 8, 12,  3, 16,  6},
    '{ 5,  4,  4,  8,  8}
  };

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             en_i = 1'b0;
  logic [CNT_W-1:0] period_i = '0;
  logic [CNT_W-1:0] cmp_a_i = '0;
  logic [CNT_W-1:0] cmp_b_i = '0;
  logic             sync_i = 1'b0;
  logic             phase_en_i = 1'b0;
  logic [CNT_W-1:0] phase_i = '0;
  logic [1:0]       force_a_i = 2'b00;
  logic [1:0]       force_b_i = 2'b00;
  logic pwm_a_o, pwm_b_o, zero_o, period_o, sync_o;
  logic alt_a, alt_b, alt_z, alt_p, alt_s;

  int n_tot = 0;
  int n_ok  = 0;
  bit done  = 1'b0;

  always #2 clk_i = ~clk_i;

  updown_pwm #(.CNT_W(CNT_W)) u_updown_pwm (
    .clk_i, .rst_ni, .en_i, .period_i, .cmp_a_i, .cmp_b_i, .sync_i,
    .phase_en_i, .phase_i, .force_a_i, .force_b_i,
    .pwm_a_o, .pwm_b_o, .zero_o, .period_o, .sync_o
  );

  updown_pwm #(.CNT_W(CNT_W), .ACT_B(ALT_B)) u_updown_pwm_alt (
    .clk_i, .rst_ni, .en_i, .period_i, .cmp_a_i, .cmp_b_i, .sync_i,
    .phase_en_i, .phase_i, .force_a_i, .force_b_i,
    .pwm_a_o(alt_a), .pwm_b_o(alt_b), .zero_o(alt_z), .period_o(alt_p), .sync_o(alt_s)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tot++;
    if (ok) n_ok++;
    else $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
  endtask

  task automatic wait_zero();
    do @(negedge clk_i); while (!zero_o);
  endtask

  task automatic measure(input int win, output int ha, output int hb, output int hb_alt);
    ha = 0; hb = 0; hb_alt = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk_i);
      ha += int'(pwm_a_o);
      hb += int'(pwm_b_o);
      hb_alt += int'(alt_b);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_tot++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_ok, n_tot);
      $finish;
    end
  end

  initial begin
    int ha, hb, hx, n, rise, zc, pc, mis, tog;
    logic last;

    // R1 reset state
    repeat (3) @(negedge clk_i);
    chk(!pwm_a_o && !pwm_b_o, "R1 outputs in reset", int'(pwm_a_o) + int'(pwm_b_o), 0);
    chk(!zero_o && !period_o && !sync_o, "R1 strobes in reset",
        int'(zero_o) + int'(period_o) + int'(sync_o), 0);
    period_i = 10; cmp_a_i = 3; cmp_b_i = 5; en_i = 1'b1;
    rst_ni = 1'b1;
    #1 chk(zero_o == 1'b1, "R1 first enabled clock at zero", int'(zero_o), 1);

    // R5 R6 vector table
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk_i);
      period_i = CNT_W'(VEC[v][0]);
      cmp_a_i  = CNT_W'(VEC[v][1]);
      cmp_b_i  = CNT_W'(VEC[v][2]);
      repeat (100) @(negedge clk_i);
      measure(2 * VEC[v][0], ha, hb, hx);
      chk(ha == VEC[v][3],
          (VEC[v][1] == 0 || VEC[v][1] >= VEC[v][0]) ? "R6 high time A" : "R5 high time A",
          ha, VEC[v][3]);
      chk(hb == VEC[v][4],
          (VEC[v][2] == 0 || VEC[v][2] >= VEC[v][0]) ? "R6 high time B" : "R5 high time B",
          hb, VEC[v][4]);
    end

    // R4 shadow change while counting down waits for the zero load
    period_i = 10; cmp_a_i = 3; cmp_b_i = 5;
    repeat (100) @(negedge clk_i);
    wait_zero();
    rise = 0;
    for (n = 1; n <= 25; n++) begin
      @(negedge clk_i);
      if (n == 12) cmp_a_i = 6;
      if (n >= 5 && pwm_a_o && rise == 0) rise = n;
    end
    chk(rise == 18, "R4 shadow held until zero", rise, 18);

    // R2 R3 long period
    period_i = 750;
    repeat (1600) @(negedge clk_i);
    wait_zero();
    n = 0; zc = 0; pc = 0; mis = 0;
    do begin
      @(negedge clk_i);
      n++;
      if (period_o && pc == 0) chk(n == 750, "R2 period strobe offset", n, 750);
      pc += int'(period_o);
      if (sync_o != zero_o) mis++;
    end while (!zero_o && n < 4000);
    chk(n == 1500, "R2 cycle length", n, 1500);
    chk(pc == 1, "R3 period strobe count", pc, 1);
    chk(mis == 0, "R3 sync_o tracks zero_o", mis, 0);
    @(negedge clk_i);
    chk(!zero_o, "R3 zero strobe one clock", int'(zero_o), 0);

    // R8 phase load and ignore
    period_i = 10; phase_i = 4;
    repeat (3) @(negedge clk_i);
    for (int pe = 0; pe < 2; pe++) begin
      wait_zero();
      phase_en_i = pe[0];
      sync_i = 1'b1;
      n = 0;
      do begin
        @(negedge clk_i);
        sync_i = 1'b0;
        n++;
      end while (!period_o && n < 40);
      chk(n == (pe == 1 ? 7 : 10), pe == 1 ? "R8 phase loaded" : "R8 sync ignored",
          n, pe == 1 ? 7 : 10);
      phase_en_i = 1'b0;
    end

    // R7 priority and action codes on the alternate instance
    cmp_b_i = 3;
    repeat (100) @(negedge clk_i);
    measure(20, ha, hb, hx);
    chk(hx == 3, "R7 zero clear after down set", hx, 3);
    chk(hb == 6, "R7 default actions reference", hb, 6);
    cmp_b_i = 0;
    repeat (100) @(negedge clk_i);
    measure(20, ha, hb, hx);
    chk(hx == 20, "R7 compare wins over zero", hx, 20);

    // R9 force
    cmp_a_i = 0; cmp_b_i = 9;
    repeat (100) @(negedge clk_i);
    force_a_i = 2'b01;
    #1 chk(pwm_a_o == 1'b0, "R9 force low immediate", int'(pwm_a_o), 0);
    measure(20, ha, hb, hx);
    chk(ha == 0, "R9 force low holds", ha, 0);
    force_a_i = 2'b00;
    #1 chk(pwm_a_o == 1'b1, "R9 release restores", int'(pwm_a_o), 1);
    force_b_i = 2'b10;
    measure(20, ha, hb, hx);
    chk(hb == 20, "R9 force high", hb, 20);
    force_b_i = 2'b11;
    measure(20, ha, hb, hx);
    chk(hb == 18, "R9 code 11 passes", hb, 18);
    force_b_i = 2'b00;

    // R10 enable low freezes
    cmp_a_i = 3;
    repeat (100) @(negedge clk_i);
    en_i = 1'b0;
    #1 last = pwm_a_o;
    zc = 0; tog = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk_i);
      zc += int'(zero_o) + int'(period_o);
      if (pwm_a_o != last) tog++;
    end
    chk(zc == 0, "R10 no strobes when disabled", zc, 0);
    chk(tog == 0, "R10 output frozen", tog, 0);
    en_i = 1'b1;
    wait_zero();
    n = 0;
    do begin @(negedge clk_i); n++; end while (!zero_o && n < 100);
    chk(n == 20, "R10 resumes full cycle", n, 20);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_ok, n_tot);
    $finish;
  end
endmodule